// File: doc/BRIEF.md
# Masked Cache-Line Refill Checker

This block checks cache-line refill events reported by a design under test against expected line contents. Each event carries a source tag, a physical address, a 512-bit data line, a per-bank select vector and three suppression flags: fault, memory-mapped I/O and uncached. A helper stage turns the bank select vector into a lane mask with one bit per 64-bit lane. Only the enabled lanes are compared. A fetch that reads only some banks of a line is therefore not reported as wrong. Refill sources that always deliver the whole line drive an all-ones bank select.

Expected lines are held in a small direct-mapped line store. The bench or environment loads it by address through a write port. An accepted event is registered for one cycle. It is then compared against the stored line that has the same line-aligned address. The block reports a one-cycle result with the source tag, the aligned address, a mismatch flag with the lowest mismatching lane, or a separate miss flag when no expected data is loaded for that line.

Top module: `masked_refill_checker`

## Requirements
- R1: Lane mask bit j equals bank select bit floor(j / (NUM_LANES / NUM_BANKS)). A bank count that is not a power of two, or that exceeds the lane count, stops elaboration.
- R2: An event is accepted only when `evValid` is 1 and `evFault`, `evMmio` and `evUncached` are all 0. A rejected event produces no `chkDone`, `mismatch` or `miss`.
- R3: An accepted event sampled at clock edge E raises `chkDone` for exactly one cycle after edge E+1. In that cycle `chkIndex` equals the event's tag and `chkAddr` equals its address with the low 6 bits (the byte offset within the 64-byte line) forced to 0.
- R4: `mismatch` is raised when at least one enabled lane differs from the expected line. Lane l covers data bits [64*l+63 : 64*l]. Lanes whose mask bit is 0 never cause a mismatch.
- R5: When `mismatch` is raised, `mismatchLane` gives the lowest-numbered enabled lane that differs.
- R6: An accepted event with an all-zero bank select passes. It raises neither `mismatch` nor `miss`, whatever its data and address.
- R7: An accepted event with a nonzero mask whose line is not held in the store raises `miss` and not `mismatch`.
- R8: A load writes the line at its aligned address into set addr[8:6]. A later load to the same line replaces the data. A load to another line with the same set evicts the earlier line.
- R9: After reset all outputs are 0 and the store holds no line, so the first checked event misses.
- R10: An all-ones bank select compares all eight lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | Write an expected line into the store |
| ldAddr | input | 36 | Physical address of the expected line (offset bits ignored) |
| ldData | input | 512 | Expected line data |
| evValid | input | 1 | Refill event strobe |
| evIndex | input | 4 | Source tag of the event |
| evAddr | input | 36 | Physical address of the refilled line |
| evData | input | 512 | Refilled line data |
| evBankSel | input | 8 | Banks read by the event |
| evFault | input | 1 | Access raised an exception; suppress |
| evMmio | input | 1 | Access targets memory-mapped I/O; suppress |
| evUncached | input | 1 | Access is uncacheable; suppress |
| chkDone | output | 1 | One-cycle pulse: a check result is present |
| chkIndex | output | 4 | Tag of the checked event |
| chkAddr | output | 36 | Line-aligned address of the checked event |
| mismatch | output | 1 | Enabled lane differs from the expected data |
| mismatchLane | output | 3 | Lowest mismatching enabled lane |
| miss | output | 1 | No expected line loaded for the address |

## Verification
The bound checker watches properties that must hold on every cycle:
- `mismatch` and `miss` are never raised together, and neither appears without `chkDone`.
- A result only follows an accepted event two edges earlier.
- An all-zero bank select never produces a flag.
- A reported lane always belongs to a selected bank.

Only the bench scenarios can show the data-dependent behaviour: that the lowest differing lane is chosen, that corruption in deselected lanes is ignored, that the aligned address and tag are echoed, and that reloads and set aliasing change the expected data as the store rules say.

// File: rtl/refill_chk_pkg.sv
package refill_chk_pkg;

  // Strobes sent from the control module to the datapath.
  typedef struct packed {
    logic capture;      // latch an accepted event into stage 1
    logic report;       // stage 1 holds an event: publish its result
    logic flagMismatch; // result is a data mismatch
    logic flagMiss;     // result is a store miss
  } ctlStrobes_t;

endpackage

// File: rtl/rc_lane_mask_expand.sv
module rc_lane_mask_expand #(
  parameter int NUM_BANKS = 8,
  parameter int NUM_LANES = 8
) (
  input  logic [NUM_BANKS-1:0] bankSel,
  output logic [NUM_LANES-1:0] laneMask
);

  localparam int LANES_PER_BANK = (NUM_BANKS > 0) ? NUM_LANES / NUM_BANKS : 1;
  localparam bit BANKS_POW2     = (NUM_BANKS > 0) && ((NUM_BANKS & (NUM_BANKS - 1)) == 0);

  generate
    if (!BANKS_POW2 || NUM_BANKS > NUM_LANES) begin : gBadCfg
      $error("rc_lane_mask_expand: bank count must be a power of two not above the lane count");
    end
    for (genvar j = 0; j < NUM_LANES; j++) begin : gLane
      assign laneMask[j] = bankSel[j / LANES_PER_BANK];
    end
  endgenerate

endmodule

// File: rtl/rc_line_store.sv
module rc_line_store #(
  parameter int PADDR_W = 36,
  parameter int LINE_W  = 512,
  parameter int DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [PADDR_W-1:0] wrAddr,
  input  logic [LINE_W-1:0]  wrData,
  input  logic [PADDR_W-1:0] rdLine,
  output logic               rdHit,
  output logic [LINE_W-1:0]  rdData
);

  localparam int OFF_W = $clog2(LINE_W / 8);
  localparam int SET_W = $clog2(DEPTH);
  localparam logic [PADDR_W-1:0] OFF_MASK = PADDR_W'((64'd1 << OFF_W) - 64'd1);

  logic [LINE_W-1:0]  lineMem [DEPTH];
  logic [PADDR_W-1:0] tagMem  [DEPTH];
  logic [DEPTH-1:0]   setValid;

  logic [PADDR_W-1:0] wrLine;
  logic [SET_W-1:0]   wrSet;
  logic [SET_W-1:0]   rdSet;

  assign wrLine = wrAddr & ~OFF_MASK;
  assign wrSet  = wrLine[OFF_W +: SET_W];
  assign rdSet  = rdLine[OFF_W +: SET_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      setValid <= '0;
    end else if (wrEn) begin
      setValid[wrSet] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      lineMem[wrSet] <= wrData;
      tagMem[wrSet]  <= wrLine;
    end
  end

  assign rdHit  = setValid[rdSet] && (tagMem[rdSet] == rdLine);
  assign rdData = lineMem[rdSet];

endmodule

// File: rtl/rc_control.sv
module rc_control
  import refill_chk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evValid,
  input  logic        evFault,
  input  logic        evMmio,
  input  logic        evUncached,
  input  logic        maskZero,
  input  logic        lineHit,
  input  logic        anyMismatch,
  output ctlStrobes_t stb
);

  logic evAccept;
  logic s1Valid;

  assign evAccept = evValid && !(evFault || evMmio || evUncached);

  always_ff @(posedge clk) begin
    if (!rst_n) s1Valid <= 1'b0;
    else        s1Valid <= evAccept;
  end

  always_comb begin
    stb              = '0;
    stb.capture      = evAccept;
    stb.report       = s1Valid;
    stb.flagMiss     = s1Valid && !maskZero && !lineHit;
    stb.flagMismatch = s1Valid && !maskZero && lineHit && anyMismatch;
  end

endmodule

// File: rtl/rc_datapath.sv
module rc_datapath
  import refill_chk_pkg::*;
#(
  parameter int PADDR_W = 36,
  parameter int LINE_W  = 512,
  parameter int LANE_W  = 64,
  parameter int IDX_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctlStrobes_t             stb,
  input  logic [IDX_W-1:0]        evIndex,
  input  logic [PADDR_W-1:0]      evAddr,
  input  logic [LINE_W-1:0]       evData,
  input  logic [LINE_W/LANE_W-1:0] laneMask,
  input  logic [LINE_W-1:0]       expData,
  output logic [PADDR_W-1:0]      s1Line,
  output logic                    maskZero,
  output logic                    anyMismatch,
  output logic                    chkDone,
  output logic [IDX_W-1:0]        chkIndex,
  output logic [PADDR_W-1:0]      chkAddr,
  output logic                    mismatch,
  output logic [$clog2(LINE_W/LANE_W)-1:0] mismatchLane,
  output logic                    miss
);

  localparam int NUM_LANES  = LINE_W / LANE_W;
  localparam int LANE_IDX_W = $clog2(NUM_LANES);
  localparam int OFF_W      = $clog2(LINE_W / 8);
  localparam logic [PADDR_W-1:0] OFF_MASK = PADDR_W'((64'd1 << OFF_W) - 64'd1);

  logic [IDX_W-1:0]      s1Index;
  logic [LINE_W-1:0]     s1Data;
  logic [NUM_LANES-1:0]  s1Mask;
  logic [NUM_LANES-1:0]  laneDiff;
  logic [LANE_IDX_W-1:0] firstLane;

  // Stage 1: accepted event, address already line aligned.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Index <= '0;
      s1Line  <= '0;
      s1Mask  <= '0;
    end else if (stb.capture) begin
      s1Index <= evIndex;
      s1Line  <= evAddr & ~OFF_MASK;
      s1Mask  <= laneMask;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.capture) s1Data <= evData;
  end

  // Per-lane gated comparison.
  generate
    for (genvar l = 0; l < NUM_LANES; l++) begin : gCmp
      assign laneDiff[l] = s1Mask[l] &&
                           (s1Data[l*LANE_W +: LANE_W] != expData[l*LANE_W +: LANE_W]);
    end
  endgenerate

  // Lowest differing lane wins.
  always_comb begin
    firstLane = '0;
    for (int l = NUM_LANES - 1; l >= 0; l--) begin
      if (laneDiff[l]) firstLane = LANE_IDX_W'(l);
    end
  end

  assign maskZero    = (s1Mask == '0);
  assign anyMismatch = |laneDiff;

  // Result registers.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chkDone      <= 1'b0;
      mismatch     <= 1'b0;
      miss         <= 1'b0;
      mismatchLane <= '0;
      chkIndex     <= '0;
      chkAddr      <= '0;
    end else begin
      chkDone  <= stb.report;
      mismatch <= stb.flagMismatch;
      miss     <= stb.flagMiss;
      if (stb.report) begin
        chkIndex     <= s1Index;
        chkAddr      <= s1Line;
        mismatchLane <= stb.flagMismatch ? firstLane : '0;
      end
    end
  end

endmodule

// File: rtl/masked_refill_checker.sv
module masked_refill_checker
  import refill_chk_pkg::*;
#(
  parameter int PADDR_W     = 36,
  parameter int LINE_W      = 512,
  parameter int LANE_W      = 64,
  parameter int NUM_BANKS   = 8,
  parameter int IDX_W       = 4,
  parameter int STORE_DEPTH = 8,
  localparam int NUM_LANES  = LINE_W / LANE_W,
  localparam int LANE_IDX_W = $clog2(NUM_LANES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ldValid,
  input  logic [PADDR_W-1:0]    ldAddr,
  input  logic [LINE_W-1:0]     ldData,
  input  logic                  evValid,
  input  logic [IDX_W-1:0]      evIndex,
  input  logic [PADDR_W-1:0]    evAddr,
  input  logic [LINE_W-1:0]     evData,
  input  logic [NUM_BANKS-1:0]  evBankSel,
  input  logic                  evFault,
  input  logic                  evMmio,
  input  logic                  evUncached,
  output logic                  chkDone,
  output logic [IDX_W-1:0]      chkIndex,
  output logic [PADDR_W-1:0]    chkAddr,
  output logic                  mismatch,
  output logic [LANE_IDX_W-1:0] mismatchLane,
  output logic                  miss
);

  ctlStrobes_t          stb;
  logic [NUM_LANES-1:0] laneMask;
  logic [PADDR_W-1:0]   s1Line;
  logic [LINE_W-1:0]    expData;
  logic                 lineHit;
  logic                 maskZero;
  logic                 anyMismatch;

  rc_lane_mask_expand #(.NUM_BANKS(NUM_BANKS), .NUM_LANES(NUM_LANES)) u_expand (
    .bankSel  (evBankSel),
    .laneMask (laneMask)
  );

  rc_line_store #(.PADDR_W(PADDR_W), .LINE_W(LINE_W), .DEPTH(STORE_DEPTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (ldValid),
    .wrAddr (ldAddr),
    .wrData (ldData),
    .rdLine (s1Line),
    .rdHit  (lineHit),
    .rdData (expData)
  );

  rc_control u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .evValid     (evValid),
    .evFault     (evFault),
    .evMmio      (evMmio),
    .evUncached  (evUncached),
    .maskZero    (maskZero),
    .lineHit     (lineHit),
    .anyMismatch (anyMismatch),
    .stb         (stb)
  );

  rc_datapath #(.PADDR_W(PADDR_W), .LINE_W(LINE_W), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (stb),
    .evIndex      (evIndex),
    .evAddr       (evAddr),
    .evData       (evData),
    .laneMask     (laneMask),
    .expData      (expData),
    .s1Line       (s1Line),
    .maskZero     (maskZero),
    .anyMismatch  (anyMismatch),
    .chkDone      (chkDone),
    .chkIndex     (chkIndex),
    .chkAddr      (chkAddr),
    .mismatch     (mismatch),
    .mismatchLane (mismatchLane),
    .miss         (miss)
  );

endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
  parameter int NUM_BANKS  = 8,
  parameter int NUM_LANES  = 8,
  parameter int LANE_IDX_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  evValid,
  input logic                  evFault,
  input logic                  evMmio,
  input logic                  evUncached,
  input logic [NUM_BANKS-1:0]  evBankSel,
  input logic                  chkDone,
  input logic                  mismatch,
  input logic [LANE_IDX_W-1:0] mismatchLane,
  input logic                  miss
);

  localparam int LANES_PER_BANK = NUM_LANES / NUM_BANKS;

  logic                 takeD1, takeD2;
  logic [NUM_BANKS-1:0] selD1, selD2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      takeD1 <= 1'b0;
      takeD2 <= 1'b0;
      selD1  <= '0;
      selD2  <= '0;
    end else begin
      takeD1 <= evValid && !evFault && !evMmio && !evUncached;
      takeD2 <= takeD1;
      selD1  <= evBankSel;
      selD2  <= selD1;
    end
  end

  // R2
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chkDone |-> takeD2);

  // R7
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mismatch && miss));

  // R3
  flag_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch || miss) |-> chkDone);

  // R6
  zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chkDone && selD2 == '0) |-> (!mismatch && !miss));

  // R4
  lane_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> selD2[mismatchLane / LANES_PER_BANK]);

endmodule

bind masked_refill_checker rc_checker #(
  .NUM_BANKS  (NUM_BANKS),
  .NUM_LANES  (NUM_LANES),
  .LANE_IDX_W (LANE_IDX_W)
) u_rc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .evValid      (evValid),
  .evFault      (evFault),
  .evMmio       (evMmio),
  .evUncached   (evUncached),
  .evBankSel    (evBankSel),
  .chkDone      (chkDone),
  .mismatch     (mismatch),
  .mismatchLane (mismatchLane),
  .miss         (miss)
);

// File: tb/masked_refill_checker_bench.sv
`timescale 1ns/1ps
module masked_refill_checker_bench;

  localparam int PADDR_W = 36;
  localparam int LINE_W  = 512;
  localparam int NLANES  = 8;
  localparam int NBANKS  = 8;
  localparam int IDX_W   = 4;
  localparam int DEPTH   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic               ldValid = 1'b0;
  logic [PADDR_W-1:0] ldAddr = '0;
  logic [LINE_W-1:0]  ldData = '0;
  logic               evValid = 1'b0;
  logic [IDX_W-1:0]   evIndex = '0;
  logic [PADDR_W-1:0] evAddr = '0;
  logic [LINE_W-1:0]  evData = '0;
  logic [NBANKS-1:0]  evBankSel = '0;
  logic               evFault = 1'b0;
  logic               evMmio = 1'b0;
  logic               evUncached = 1'b0;
  logic               chkDone;
  logic [IDX_W-1:0]   chkIndex;
  logic [PADDR_W-1:0] chkAddr;
  logic               mismatch;
  logic [2:0]         mismatchLane;
  logic               miss;

  masked_refill_checker u_masked_refill_checker (
    .clk(clk), .rst_n(rst_n),
    .ldValid(ldValid), .ldAddr(ldAddr), .ldData(ldData),
    .evValid(evValid), .evIndex(evIndex), .evAddr(evAddr), .evData(evData),
    .evBankSel(evBankSel), .evFault(evFault), .evMmio(evMmio), .evUncached(evUncached),
    .chkDone(chkDone), .chkIndex(chkIndex), .chkAddr(chkAddr),
    .mismatch(mismatch), .mismatchLane(mismatchLane), .miss(miss)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // Bench model of the expected-line store.
  logic [PADDR_W-1:0] mTag   [DEPTH];
  logic [LINE_W-1:0]  mData  [DEPTH];
  logic [DEPTH-1:0]   mValid = '0;

  function automatic logic [PADDR_W-1:0] alignOf(logic [PADDR_W-1:0] a);
    return {a[PADDR_W-1:6], 6'd0};
  endfunction

  function automatic logic [NLANES-1:0] maskOf(logic [NBANKS-1:0] sel);
    logic [NLANES-1:0] m;
    for (int j = 0; j < NLANES; j++) m[j] = sel[j / (NLANES / NBANKS)];
    return m;
  endfunction

  function automatic logic [LINE_W-1:0] rndLine();
    logic [LINE_W-1:0] r;
    for (int i = 0; i < LINE_W / 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [LINE_W-1:0] flipLanes(logic [LINE_W-1:0] d, logic [NLANES-1:0] lanes);
    logic [LINE_W-1:0] r = d;
    for (int l = 0; l < NLANES; l++)
      if (lanes[l]) r[l*64 +: 64] = r[l*64 +: 64] ^ {32'h0, $urandom | 32'h1};
    return r;
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic loadLine(logic [PADDR_W-1:0] a, logic [LINE_W-1:0] d);
    int s;
    @(negedge clk);
    ldValid = 1'b1; ldAddr = a; ldData = d;
    @(negedge clk);
    ldValid = 1'b0;
    s = int'(a[8:6]);
    mTag[s] = alignOf(a); mData[s] = d; mValid[s] = 1'b1;
  endtask

  // Drive one event, compute the expected result, and compare at the ports.
  task automatic runEvent(string req, logic vld, logic [IDX_W-1:0] idx, logic [PADDR_W-1:0] a,
                          logic [LINE_W-1:0] d, logic [NBANKS-1:0] sel,
                          logic f, logic m, logic u);
    logic take, eMis, eMiss;
    logic [2:0] eLane;
    logic [NLANES-1:0] msk, diff;
    int s;
    take = vld && !f && !m && !u;
    msk  = maskOf(sel);
    s    = int'(a[8:6]);
    eMis = 1'b0; eMiss = 1'b0; eLane = '0; diff = '0;
    if (take && msk != '0) begin
      if (!(mValid[s] && mTag[s] == alignOf(a))) eMiss = 1'b1;
      else begin
        for (int l = 0; l < NLANES; l++)
          diff[l] = msk[l] && (d[l*64 +: 64] != mData[s][l*64 +: 64]);
        eMis = |diff;
        for (int l = NLANES - 1; l >= 0; l--) if (diff[l]) eLane = 3'(l);
      end
    end
    @(negedge clk);
    evValid = vld; evIndex = idx; evAddr = a; evData = d; evBankSel = sel;
    evFault = f; evMmio = m; evUncached = u;
    @(negedge clk);
    evValid = 1'b0; evFault = 1'b0; evMmio = 1'b0; evUncached = 1'b0;
    @(negedge clk);
    check(req, "chkDone", 64'(chkDone), 64'(take));
    check(req, "mismatch", 64'(mismatch), 64'(eMis));
    check(req, "miss", 64'(miss), 64'(eMiss));
    if (eMis) check(req, "mismatchLane", 64'(mismatchLane), 64'(eLane));
    if (take) begin
      check(req, "chkIndex", 64'(chkIndex), 64'(idx));
      check(req, "chkAddr", 64'(chkAddr), 64'(alignOf(a)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [PADDR_W-1:0] aA, aB, aC;
    logic [LINE_W-1:0]  dA, dB, dC;
    logic [PADDR_W-1:0] pool [6];
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R9: reset state of the outputs
    check("R9", "chkDone", 64'(chkDone), 0);
    check("R9", "mismatch", 64'(mismatch), 0);
    check("R9", "miss", 64'(miss), 0);
    rst_n = 1'b1;

    aA = 36'h1_2345_6040; aB = 36'h0_0ABC_0080; aC = 36'h7_0000_0040; // aC aliases aA's set
    dA = rndLine(); dB = rndLine(); dC = rndLine();

    // R9: empty store misses
    runEvent("R9", 1'b1, 4'd3, aA, dA, 8'hFF, 1'b0, 1'b0, 1'b0);
    loadLine(aA, dA);
    loadLine(aB, dB);
    // R10: full line match, then corruption anywhere detected
    runEvent("R10", 1'b1, 4'd0, aA, dA, 8'hFF, 1'b0, 1'b0, 1'b0);
    runEvent("R10", 1'b1, 4'd1, aB, flipLanes(dB, 8'h80), 8'hFF, 1'b0, 1'b0, 1'b0);
    // R4 R5: lowest differing lane reported
    runEvent("R5", 1'b1, 4'd2, aA, flipLanes(dA, 8'h44), 8'hFF, 1'b0, 1'b0, 1'b0);
    // R1 R4: five banks read, corruption in lanes 5..7 ignored
    runEvent("R4", 1'b1, 4'd3, aA, flipLanes(dA, 8'hE0), 8'h1F, 1'b0, 1'b0, 1'b0);
    runEvent("R1", 1'b1, 4'd4, aA, flipLanes(dA, 8'hF0), 8'h1F, 1'b0, 1'b0, 1'b0);
    // R6: zero mask on unloaded line with bad data passes
    runEvent("R6", 1'b1, 4'd5, aC, rndLine(), 8'h00, 1'b0, 1'b0, 1'b0);
    // R2: invalid and suppressed events produce nothing
    runEvent("R2", 1'b0, 4'd3, aA, flipLanes(dA, 8'hFF), 8'hFF, 1'b0, 1'b0, 1'b0);
    runEvent("R2", 1'b1, 4'd3, aA, flipLanes(dA, 8'hFF), 8'hFF, 1'b1, 1'b0, 1'b0);
    runEvent("R2", 1'b1, 4'd4, aC, dC, 8'hFF, 1'b0, 1'b1, 1'b0);
    runEvent("R2", 1'b1, 4'd4, aA, flipLanes(dA, 8'h01), 8'hFF, 1'b0, 1'b0, 1'b1);
    // R3: unaligned address is reported aligned, tag echoed, pulse is one cycle
    runEvent("R3", 1'b1, 4'd9, aB | 36'h3B, dB, 8'hFF, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R3", "chkDone pulse end", 64'(chkDone), 0);
    // R8: reload replaces data, alias evicts
    dA = rndLine();
    loadLine(aA, dA);
    runEvent("R8", 1'b1, 4'd3, aA, dA, 8'hFF, 1'b0, 1'b0, 1'b0);
    loadLine(aC, dC);
    runEvent("R8", 1'b1, 4'd3, aA, dA, 8'hFF, 1'b0, 1'b0, 1'b0);
    runEvent("R7", 1'b1, 4'd4, aA, dA, 8'h01, 1'b0, 1'b0, 1'b0);
    runEvent("R8", 1'b1, 4'd4, aC, dC, 8'h3C, 1'b0, 1'b0, 1'b0);

    // Constrained random mix (R4 R5 R7 R8 R1 R2 R6)
    for (int i = 0; i < 6; i++)
      pool[i] = {4'($urandom_range(0, 3)), 20'h0, 3'($urandom), 3'(i), 6'($urandom)};
    for (int i = 0; i < 400; i++) begin
      int p;
      logic [LINE_W-1:0] d;
      logic [NBANKS-1:0] sel;
      logic [2:0] sup;
      p = $urandom_range(0, 5);
      if ($urandom_range(0, 7) == 0) loadLine(pool[p], rndLine());
      d = (mValid[pool[p][8:6]] && mTag[pool[p][8:6]] == alignOf(pool[p]))
          ? mData[pool[p][8:6]] : rndLine();
      if ($urandom_range(0, 1) == 1) d = flipLanes(d, 8'($urandom));
      case ($urandom_range(0, 3))
        0: sel = 8'hFF;
        1: sel = 8'h1F << $urandom_range(0, 3);
        2: sel = 8'($urandom);
        default: sel = 8'h00;
      endcase
      sup = ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'b000;
      runEvent("R4", $urandom_range(0, 9) != 0, 4'($urandom_range(3, 4)), pool[p], d, sel,
               sup[0], sup[1], sup[2]);
    end
    finishRun();
  end

endmodule